// File: doc/BRIEF.md
# SD Command Line Framer

This block issues one command on the command line of an SD card running in native mode and collects the reply. The caller gives a 6-bit command index, a 32-bit argument and a choice of checksum. The checksum is either a fixed byte supplied by the caller or a CRC7 that the block computes as the bits go out. After a pulse on `start`, the block leaves the line released for a run of idle clocks. It then drives the 48-bit frame, gives one more high clock, and releases the line again.

The expected reply length comes from the command index. A command with no reply finishes at once. For any other command the block samples the line each clock until it sees a low start bit, and gives up after a timeout the caller sets. Reply bits are packed most significant bit first into a byte buffer that the caller reads by index. Each block clock is one SD clock period. The block does not handle the data lines, the card start-up sequence or checking the reply CRC.

Top module: `sdcmd_framer`

## Requirements
- R1: After reset, `busy`, `done`, `timed_out` and `cmd_oe` are all 0.
- R2: After `start` is accepted, `cmd_oe` stays 0 for exactly PRE_CLKS clocks (default 9, never fewer than 8) before the first frame bit.
- R3: The frame goes out one bit per clock while `cmd_oe` is 1, most significant bit first. Its first byte is 0x40 ORed with the command index, and the four argument bytes follow, most significant byte first.
- R4: When `crc_fixed_en` is 0, the sixth byte is the CRC7 of the first 40 frame bits (polynomial x^7+x^3+1, initial value 0) shifted left by one, with bit 0 set to 1. For example, index 0 with argument 0 gives 0x95, and index 8 with argument 0x000001AA gives 0x87.
- R5: When `crc_fixed_en` is 1, the sixth byte is `crc_fixed`, sent unchanged.
- R6: After the 48 frame bits, the block drives one further clock with `cmd_out`=1 and `cmd_oe`=1, then releases the line. `cmd_oe` is 0 in every state other than these 49 clocks.
- R7: `rsp_bytes` gives the reply length: 0 for index 0, 17 for indices 2 and 9, and 6 for every other index. With length 0, `done` rises on the clock after the extra high clock and no reply is sampled.
- R8: The reply is captured starting with the first low sample, which becomes bit 7 of byte 0. The bits fill `rsp_bytes` bytes, each most significant bit first, and byte i is read at `rsp_rd_data` while `rsp_rd_idx`=i.
- R9: If `cmd_in` is sampled high on `timeout_limit` consecutive clocks after release (a limit of 0 acts as 1), `done` and `timed_out` rise together on the clock after the last such sample. `timed_out` stays set until the next accepted `start`, and is 0 after a reply is received.
- R10: `busy` is 1 from the clock after an accepted `start` until `done`. `done` is a one-clock pulse, after which `busy` is 0. A `start` pulse while `busy` is 1 is ignored and does not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one SD clock period per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| crc_fixed_en | input | 1 | 1: send `crc_fixed` as last byte; 0: compute CRC7 |
| crc_fixed | input | 8 | Caller-supplied last byte |
| timeout_limit | input | TO_W | Maximum clocks to wait for a reply start bit |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| timed_out | output | 1 | Last command got no reply start bit |
| rsp_bytes | output | LEN_W | Reply length of the current command |
| rsp_rd_idx | input | IDX_W | Reply buffer read index |
| rsp_rd_data | output | 8 | Reply byte at `rsp_rd_idx` |

## Verification
The assertions check on every cycle that the drive enable is low while the block is idle and that each driven run lasts exactly 49 clocks. They also check that a driven run starts with a low bit and ends with a high one, that `done` never lasts two clocks, that `busy` rises only after `start`, and that a timeout appears only together with `done` and never on a command with no reply. The frame contents (header, argument, computed or fixed checksum), the preamble length, the reply byte packing and the exact timeout moment depend on each command's data. Only the bench's scenarios show these, by comparing against values the bench computes itself. The same holds for a `start` pulse sent in the middle of a frame being ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   localparam int FRAME_BITS = 48;
   localparam int HEAD_BITS  = 40;
   localparam int DRIVE_RUN  = FRAME_BITS + 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_TX,
      ST_GAP,
      ST_WAIT,
      ST_RX,
      ST_DONE
   } sdcmd_state_t;

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
   parameter int               WIDTH = 7,
   parameter logic [WIDTH-1:0] POLY  = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [WIDTH-1:0] crc
);

   logic fb;
   assign fb = bit_in ^ crc[WIDTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= '0;
      else if (clear)
         crc <= '0;
      else if (shift_en)
         crc <= {crc[WIDTH-2:0], 1'b0} ^ (POLY & {WIDTH{fb}});
   end

endmodule

// File: rtl/sdcmd_rsp_decode.sv
module sdcmd_rsp_decode #(
   parameter int LONG_BYTES  = 17,
   parameter int SHORT_BYTES = 6,
   parameter int LEN_W       = $clog2(LONG_BYTES + 1)
) (
   input  logic [5:0]       cmd_index,
   output logic [LEN_W-1:0] rsp_len
);

   always_comb begin
      unique case (cmd_index)
         6'd0:       rsp_len = '0;
         6'd2, 6'd9: rsp_len = LEN_W'(LONG_BYTES);
         default:    rsp_len = LEN_W'(SHORT_BYTES);
      endcase
   end

endmodule

// File: rtl/sdcmd_rsp_buf.sv
module sdcmd_rsp_buf #(
   parameter int BYTES = 17,
   parameter int IDX_W = $clog2(BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);

   logic [BYTES*8-1:0] flat;

   for (genvar g = 0; g < BYTES; g++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            q <= wr_data;
      end
      assign flat[g*8 +: 8] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < BYTES; i++)
         if (rd_idx == IDX_W'(i))
            rd_data = flat[i*8 +: 8];
   end

endmodule

// File: rtl/sdcmd_framer.sv
module sdcmd_framer
   import sdcmd_pkg::*;
#(
   parameter int PRE_CLKS    = 9,
   parameter int LONG_BYTES  = 17,
   parameter int SHORT_BYTES = 6,
   parameter int TO_W        = 24,
   parameter int LEN_W       = $clog2(LONG_BYTES + 1),
   parameter int IDX_W       = $clog2(LONG_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [5:0]       cmd_index,
   input  logic [31:0]      cmd_arg,
   input  logic             crc_fixed_en,
   input  logic [7:0]       crc_fixed,
   input  logic [TO_W-1:0]  timeout_limit,
   input  logic             cmd_in,
   output logic             cmd_out,
   output logic             cmd_oe,
   output logic             busy,
   output logic             done,
   output logic             timed_out,
   output logic [LEN_W-1:0] rsp_bytes,
   input  logic [IDX_W-1:0] rsp_rd_idx,
   output logic [7:0]       rsp_rd_data
);

   localparam int CNT_W = $clog2(FRAME_BITS + PRE_CLKS + 1);
   localparam int RXB_W = $clog2(LONG_BYTES * 8 + 1);

   if (PRE_CLKS < 8) begin : g_bad_pre
      $error("PRE_CLKS must be at least 8");
   end
   if (SHORT_BYTES < 1 || SHORT_BYTES > LONG_BYTES) begin : g_bad_len
      $error("SHORT_BYTES must lie in 1..LONG_BYTES");
   end
   if (TO_W < 1) begin : g_bad_to
      $error("TO_W must be positive");
   end

   sdcmd_state_t           state;
   logic [CNT_W-1:0]       cnt;
   logic [HEAD_BITS-1:0]   head;
   logic                   fix_q;
   logic [7:0]             fixcrc_q;
   logic [LEN_W-1:0]       len_q;
   logic [TO_W-1:0]        limit_q;
   logic [TO_W-1:0]        wait_cnt;
   logic [RXB_W-1:0]       rx_bits;
   logic [7:0]             cur;
   logic                   tmo_q;

   logic [LEN_W-1:0]       dec_len;
   logic [6:0]             crc;
   logic                   accept;
   logic [7:0]             tail_byte;
   logic [2:0]             tail_sel;
   logic                   tx_bit;
   logic [RXB_W-1:0]       last_bit;
   logic                   wr_en;
   logic                   wait_expired;

   assign accept = (state == ST_IDLE) && start;

   sdcmd_rsp_decode #(
      .LONG_BYTES (LONG_BYTES),
      .SHORT_BYTES(SHORT_BYTES),
      .LEN_W      (LEN_W)
   ) u_decode (
      .cmd_index(cmd_index),
      .rsp_len  (dec_len)
   );

   sdcmd_crc7 u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .shift_en((state == ST_TX) && (cnt < CNT_W'(HEAD_BITS))),
      .bit_in  (head[HEAD_BITS-1]),
      .crc     (crc)
   );

   assign tail_byte = fix_q ? fixcrc_q : {crc, 1'b1};
   assign tail_sel  = 3'(CNT_W'(FRAME_BITS - 1) - cnt);
   assign tx_bit    = (cnt < CNT_W'(HEAD_BITS)) ? head[HEAD_BITS-1] : tail_byte[tail_sel];

   assign last_bit     = RXB_W'({len_q, 3'b000}) - RXB_W'(1);
   assign wait_expired = ({1'b0, wait_cnt} + (TO_W+1)'(1)) >= {1'b0, limit_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         head     <= '0;
         fix_q    <= 1'b0;
         fixcrc_q <= '0;
         len_q    <= '0;
         limit_q  <= '0;
         wait_cnt <= '0;
         rx_bits  <= '0;
         cur      <= '0;
         tmo_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_PRE;
               cnt      <= '0;
               head     <= {2'b01, cmd_index, cmd_arg};
               fix_q    <= crc_fixed_en;
               fixcrc_q <= crc_fixed;
               len_q    <= dec_len;
               limit_q  <= timeout_limit;
               tmo_q    <= 1'b0;
            end
            ST_PRE: begin
               if (cnt == CNT_W'(PRE_CLKS - 1)) begin
                  state <= ST_TX;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_TX: begin
               head <= {head[HEAD_BITS-2:0], 1'b0};
               if (cnt == CNT_W'(FRAME_BITS - 1))
                  state <= ST_GAP;
               else
                  cnt <= cnt + CNT_W'(1);
            end
            ST_GAP: begin
               wait_cnt <= '0;
               state    <= (len_q == '0) ? ST_DONE : ST_WAIT;
            end
            ST_WAIT: begin
               if (!cmd_in) begin
                  state   <= ST_RX;
                  cur     <= '0;
                  rx_bits <= RXB_W'(1);
               end else if (wait_expired) begin
                  state <= ST_DONE;
                  tmo_q <= 1'b1;
               end else begin
                  wait_cnt <= wait_cnt + TO_W'(1);
               end
            end
            ST_RX: begin
               cur     <= {cur[6:0], cmd_in};
               rx_bits <= rx_bits + RXB_W'(1);
               if (rx_bits == last_bit)
                  state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_en = (state == ST_RX) && (rx_bits[2:0] == 3'd7);

   sdcmd_rsp_buf #(
      .BYTES(LONG_BYTES),
      .IDX_W(IDX_W)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (IDX_W'(rx_bits >> 3)),
      .wr_data({cur[6:0], cmd_in}),
      .rd_idx (rsp_rd_idx),
      .rd_data(rsp_rd_data)
   );

   assign cmd_oe    = (state == ST_TX) || (state == ST_GAP);
   assign cmd_out   = (state == ST_TX) ? tx_bit : 1'b1;
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign timed_out = tmo_q;
   assign rsp_bytes = len_q;

endmodule

// File: rtl/sdcmd_framer_chk.sv
module sdcmd_framer_chk
   import sdcmd_pkg::*;
#(
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             timed_out,
   input logic             cmd_oe,
   input logic             cmd_out,
   input logic [LEN_W-1:0] rsp_bytes
);

   logic [6:0] oe_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         oe_run <= '0;
      else
         oe_run <= cmd_oe ? oe_run + 7'd1 : 7'd0;
   end

   p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_oe);

   p_drive_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> (oe_run == 7'(DRIVE_RUN)));

   p_gap_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> $past(cmd_out));

   p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_oe) |-> !cmd_out);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_timeout_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timed_out) |-> done);

   p_no_reply_no_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (rsp_bytes == '0)) |-> !timed_out);

endmodule

bind sdcmd_framer sdcmd_framer_chk #(.LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .timed_out(timed_out),
   .cmd_oe   (cmd_oe),
   .cmd_out  (cmd_out),
   .rsp_bytes(rsp_bytes)
);

// File: tb/sdcmd_framer_test.sv
module sdcmd_framer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  cmd_index = '0;
   logic [31:0] cmd_arg = '0;
   logic        crc_fixed_en = 1'b0;
   logic [7:0]  crc_fixed = '0;
   logic [23:0] timeout_limit = '0;
   logic        cmd_in = 1'b1;
   logic        cmd_out, cmd_oe, busy, done, timed_out;
   logic [4:0]  rsp_bytes;
   logic [4:0]  rsp_rd_idx = '0;
   logic [7:0]  rsp_rd_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sdcmd_framer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
      .cmd_arg(cmd_arg), .crc_fixed_en(crc_fixed_en), .crc_fixed(crc_fixed),
      .timeout_limit(timeout_limit), .cmd_in(cmd_in), .cmd_out(cmd_out),
      .cmd_oe(cmd_oe), .busy(busy), .done(done), .timed_out(timed_out),
      .rsp_bytes(rsp_bytes), .rsp_rd_idx(rsp_rd_idx), .rsp_rd_data(rsp_rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7_ref(input logic [39:0] bits);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic top = c[6] ^ bits[i];
         c = {c[5:0], 1'b0};
         if (top) c = c ^ 7'b0001001;
      end
      return c;
   endfunction

   function automatic int exp_len(input logic [5:0] idx);
      if (idx == 6'd0) return 0;
      if (idx == 6'd2 || idx == 6'd9) return 17;
      return 6;
   endfunction

   // One complete command with a modelled card on the line.
   task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit fx,
                          input logic [7:0] fxv, input int limit, input int delay,
                          input bit respond, input bit glitch);
      logic [47:0] got;
      logic [39:0] head;
      logic [7:0]  tail;
      logic [7:0]  rb [17];
      int          n, pre, polls, eff;
      bit          expect_to;
      head = {2'b01, idx, arg};
      tail = fx ? fxv : {crc7_ref(head), 1'b1};
      n    = exp_len(idx);
      eff  = (limit == 0) ? 1 : limit;
      expect_to = !respond || (delay >= eff);
      for (int i = 0; i < 17; i++) rb[i] = 8'($urandom);
      rb[0][7] = 1'b0;

      @(negedge clk);
      cmd_index = idx; cmd_arg = arg; crc_fixed_en = fx; crc_fixed = fxv;
      timeout_limit = 24'(limit); cmd_in = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
      pre = 0;
      while (!cmd_oe && pre < 40) begin pre++; @(negedge clk); end
      chk(pre == 9, "R2 preamble clocks", 64'(pre), 64'd9);
      for (int k = 0; k < 48; k++) begin
         got[47-k] = cmd_oe ? cmd_out : 1'bx;
         if (glitch && k == 20) begin
            cmd_index = ~idx; cmd_arg = ~arg; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(got[47:8] === head, "R3 header and argument", 64'(got[47:8]), 64'(head));
      chk(got[7:0] === tail, fx ? "R5 fixed last byte" : "R4 computed CRC7 byte",
          64'(got[7:0]), 64'(tail));
      chk(cmd_oe && cmd_out, "R6 extra high clock", 64'({cmd_oe, cmd_out}), 64'd3);
      @(negedge clk);
      chk(!cmd_oe, "R6 line released", 64'(cmd_oe), 64'd0);
      chk(rsp_bytes == 5'(n), "R7 reply length", 64'(rsp_bytes), 64'(n));
      if (n == 0) begin
         chk(done && !timed_out, "R7 no reply done at once", 64'({done, timed_out}), 64'd2);
         @(negedge clk);
         return;
      end
      polls = 0;
      if (!expect_to) begin
         for (int d = 0; d < delay; d++) begin cmd_in = 1'b1; @(negedge clk); polls++; end
         for (int b = 0; b < n * 8; b++) begin
            cmd_in = rb[b/8][7 - (b % 8)];
            @(negedge clk);
            polls++;
         end
         cmd_in = 1'b1;
      end
      while (!done && polls < eff + 300) begin @(negedge clk); polls++; end
      chk(done == 1'b1, "R10 done pulse", 64'(done), 64'd1);
      chk(timed_out == expect_to, "R9 timeout flag", 64'(timed_out), 64'(expect_to));
      if (expect_to)
         chk(polls == eff, "R9 timeout moment", 64'(polls), 64'(eff));
      else
         chk(polls == delay + n * 8, "R8 reply end moment", 64'(polls), 64'(delay + n * 8));
      @(negedge clk);
      chk(!done && !busy, "R10 one-clock done", 64'({done, busy}), 64'd0);
      if (!expect_to) begin
         for (int i = 0; i < n; i++) begin
            rsp_rd_idx = 5'(i);
            #1;
            chk(rsp_rd_data == rb[i], "R8 reply byte", 64'(rsp_rd_data), 64'(rb[i]));
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk({busy, done, timed_out, cmd_oe} == 4'b0, "R1 reset state",
          64'({busy, done, timed_out, cmd_oe}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, timed_out, cmd_oe} == 4'b0, "R1 idle after reset",
          64'({busy, done, timed_out, cmd_oe}), 64'd0);

      run_cmd(6'd0, 32'h0, 1'b0, 8'h00, 10, 0, 1'b0, 1'b0);      // R4 expect 0x95, R7 no reply
      chk(crc7_ref({2'b01, 6'd0, 32'h0}) == 7'h4A, "R4 known value 0x95", 64'(crc7_ref(40'h4000000000)), 64'h4A);
      run_cmd(6'd8, 32'h1AA, 1'b0, 8'h00, 20, 3, 1'b1, 1'b0);    // R4 expect 0x87
      chk({crc7_ref({2'b01, 6'd8, 32'h1AA}), 1'b1} == 8'h87, "R4 known value 0x87",
          64'({crc7_ref({2'b01, 6'd8, 32'h1AA}), 1'b1}), 64'h87);
      run_cmd(6'd12, 32'h0, 1'b1, 8'h61, 20, 0, 1'b1, 1'b0);     // R5
      run_cmd(6'd2, 32'h0, 1'b1, 8'h4D, 30, 2, 1'b1, 1'b0);      // R7 long, R8
      run_cmd(6'd9, 32'hABCD0000, 1'b0, 8'h00, 30, 5, 1'b1, 1'b0);
      run_cmd(6'd13, 32'h12340000, 1'b0, 8'h00, 5, 0, 1'b0, 1'b0); // R9 timeout
      run_cmd(6'd17, 32'h00000200, 1'b0, 8'h00, 4, 3, 1'b1, 1'b0); // R9 just in time
      run_cmd(6'd17, 32'h00000200, 1'b0, 8'h00, 4, 4, 1'b1, 1'b0); // R9 one too late
      run_cmd(6'd55, 32'hFFFFFFFF, 1'b0, 8'h00, 0, 0, 1'b0, 1'b0); // R9 limit 0 acts as 1
      run_cmd(6'd18, 32'h5A5A5A5A, 1'b0, 8'h00, 16, 1, 1'b1, 1'b1); // R10 start ignored
      for (int r = 0; r < 24; r++) begin
         logic [5:0] ri = 6'($urandom);
         run_cmd(ri, $urandom, 1'($urandom), 8'($urandom) | 8'h01, 8,
                 int'($urandom % 10), 1'b1, 1'($urandom % 4 == 0));
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule